// File: doc/BRIEF.md
# Link Start-Up Handshake Controller

This block sequences one end of a full-duplex serial link from power-up to the point where user traffic may flow, and brings it back to the beginning whenever the link breaks. Once per received frame the receiver reports a one-word classification: a frame error, a data frame, or one of two fill patterns. The controller uses that report to choose three things:

- which frame the local transmitter sends next: fill pattern 0, fill pattern 1 or user data;
- whether the receive loop runs in frequency-detect or phase-detect mode;
- whether the user is told that the link is ready for data.

Both ends of a link carry identical copies, and each copy runs on its own. Fill pattern 0 works as a restart request to the far end. Fill pattern 1 announces that the local receiver has locked. User data stays blocked until both directions of the link have locked in frequency and in phase.

The controller has four states:

| State | Loop mode | Transmitter sends | Ready |
|---|---|---|---|
| Start | frequency detect | fill 0 | low |
| Lock wait | frequency detect | fill 1 | low |
| Peer wait | phase detect | fill 1 | low |
| Run | phase detect | data when offered, otherwise fill 1 | high |

Two parameters set how many consecutive good frames qualify each lock step. A frame error, or a frame that does not fit the step, clears that running count.

Top module: `link_handshake_ctrl`

## Requirements
- R1: After reset the controller is in Start: `fdet_mode`=1, `tx_frame_sel`=0 (fill 0) and `rdy_for_data`=0.
- R2: `rx_status` uses these codes: 0 is frame error, 1 is data, 2 is fill 0 and 3 is fill 1. It is acted on only in cycles where `frame_strobe` is high. In any other cycle neither the state nor the outputs change.
- R3: In Start, `FILL_QUAL_FRAMES` consecutive fill frames (code 2 or 3) move the controller to Lock wait: `fdet_mode`=1, `tx_frame_sel`=1 (fill 1), `rdy_for_data`=0. A frame error or a data frame clears the count.
- R4: In Lock wait, `FREQ_QUAL_FRAMES` consecutive fill-1 frames move the controller to Peer wait: `fdet_mode`=0, `tx_frame_sel`=1, `rdy_for_data`=0. A data frame clears the count.
- R5: A frame error in Lock wait, Peer wait or Run returns the controller to Start, so fill 0 goes out to the far end.
- R6: A fill-0 frame in Lock wait, Peer wait or Run returns the controller to Start with the qualification count cleared. In Start, a fill-0 frame counts as a good fill frame.
- R7: In Peer wait, a fill-1 frame or a data frame moves the controller to Run: `fdet_mode`=0 and `rdy_for_data`=1.
- R8: In Run, `tx_frame_sel` is 2 (user data) while `user_avail` is high and 1 (fill 1) while it is low.
- R9: In Run, `rdy_for_data` falls in the same cycle as a strobed frame error or fill-0 frame.
- R10: While `fdet_mode` is 1, `tx_frame_sel` is never 2 and `rdy_for_data` is 0.
- R11: `rdy_for_data` rises only in the cycle after a strobed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_strobe | input | 1 | High for one cycle at each received frame boundary |
| rx_status | input | 2 | Classification of the received frame: 0 error, 1 data, 2 fill 0, 3 fill 1 |
| user_avail | input | 1 | The user offers a data frame |
| fdet_mode | output | 1 | 1 selects frequency detect for the receive loop, 0 selects phase detect |
| tx_frame_sel | output | 2 | Frame for the transmitter: 0 fill 0, 1 fill 1, 2 user data |
| rdy_for_data | output | 1 | The link accepts user data |

## Verification
The bench builds the controller with `FILL_QUAL_FRAMES`=3 and `FREQ_QUAL_FRAMES`=4. With these short windows, the bench can cut a run short one frame before the threshold and then finish it again, and it can walk every path back to Start many times within a short run. Because the two values differ, a design that swapped the two windows would show up. A design that counted a step one frame long or short would show up too.

// File: rtl/lnk_hs_pkg.sv
package lnk_hs_pkg;

  typedef enum logic [1:0] {
    RX_FERR  = 2'd0,
    RX_DATA  = 2'd1,
    RX_FILL0 = 2'd2,
    RX_FILL1 = 2'd3
  } rx_cond_e;

  typedef enum logic [1:0] {
    TX_FILL0 = 2'd0,
    TX_FILL1 = 2'd1,
    TX_USER  = 2'd2
  } tx_sel_e;

  typedef enum logic [1:0] {
    HS_START     = 2'd0,
    HS_WAIT_LOCK = 2'd1,
    HS_WAIT_PEER = 2'd2,
    HS_RUN       = 2'd3
  } hs_state_e;

  typedef struct packed {
    logic    fdet;
    tx_sel_e tx_sel;
    logic    ready;
  } hs_out_t;

endpackage

// File: rtl/lhs_rst_sync.sv
module lhs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/lhs_qual_counter.sv
module lhs_qual_counter
  import lnk_hs_pkg::*;
#(
  parameter int unsigned FILL_FRAMES = 16,
  parameter int unsigned FREQ_FRAMES = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_strobe,
  input  hs_state_e state,
  input  rx_cond_e  cond,
  output logic      qual_hit
);
  localparam int unsigned MAX_FRAMES = (FILL_FRAMES > FREQ_FRAMES) ? FILL_FRAMES : FREQ_FRAMES;
  localparam int unsigned CNT_W      = $clog2(MAX_FRAMES + 1);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(FILL_FRAMES - 1);
  localparam logic [CNT_W-1:0] FREQ_LAST = CNT_W'(FREQ_FRAMES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_val;
  logic             counting, good, cnt_en;

  always_comb begin
    counting = 1'b0;
    good     = 1'b0;
    last_val = '0;
    case (state)
      HS_START: begin
        counting = 1'b1;
        good     = (cond == RX_FILL0) || (cond == RX_FILL1);
        last_val = FILL_LAST;
      end
      HS_WAIT_LOCK: begin
        counting = 1'b1;
        good     = (cond == RX_FILL1);
        last_val = FREQ_LAST;
      end
      default: ;
    endcase
  end

  assign qual_hit = frame_strobe && counting && good && (cnt_q == last_val);
  assign cnt_en   = frame_strobe;

  always_comb begin
    if (!counting || !good || qual_hit) cnt_d = '0;
    else                                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_QUAL_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && cond == RX_FERR) |=> (cnt_q == '0)); // R3
  AST_QUAL_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/lhs_next_state.sv
module lhs_next_state
  import lnk_hs_pkg::*;
(
  input  hs_state_e state,
  input  logic      frame_strobe,
  input  rx_cond_e  cond,
  input  logic      qual_hit,
  output hs_state_e state_d
);
  logic restart;

  assign restart = (cond == RX_FERR) || (cond == RX_FILL0);

  always_comb begin
    state_d = state;
    if (frame_strobe) begin
      case (state)
        HS_START: begin
          if (qual_hit) state_d = HS_WAIT_LOCK;
        end
        HS_WAIT_LOCK: begin
          if (restart)       state_d = HS_START;
          else if (qual_hit) state_d = HS_WAIT_PEER;
        end
        HS_WAIT_PEER: begin
          if (restart) state_d = HS_START;
          else         state_d = HS_RUN;
        end
        HS_RUN: begin
          if (restart) state_d = HS_START;
        end
        default: state_d = HS_START;
      endcase
    end
  end
endmodule

// File: rtl/lhs_out_decode.sv
module lhs_out_decode
  import lnk_hs_pkg::*;
(
  input  hs_state_e state,
  input  logic      frame_strobe,
  input  rx_cond_e  cond,
  input  logic      user_avail,
  output hs_out_t   outs
);
  logic drop_now;

  assign drop_now = frame_strobe && ((cond == RX_FERR) || (cond == RX_FILL0));

  always_comb begin
    outs = '{fdet: 1'b1, tx_sel: TX_FILL0, ready: 1'b0};
    case (state)
      HS_START:     outs = '{fdet: 1'b1, tx_sel: TX_FILL0, ready: 1'b0};
      HS_WAIT_LOCK: outs = '{fdet: 1'b1, tx_sel: TX_FILL1, ready: 1'b0};
      HS_WAIT_PEER: outs = '{fdet: 1'b0, tx_sel: TX_FILL1, ready: 1'b0};
      HS_RUN: begin
        outs.fdet   = 1'b0;
        outs.tx_sel = user_avail ? TX_USER : TX_FILL1;
        outs.ready  = !drop_now;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/link_handshake_ctrl.sv
module link_handshake_ctrl
  import lnk_hs_pkg::*;
#(
  parameter int unsigned FILL_QUAL_FRAMES = 16,
  parameter int unsigned FREQ_QUAL_FRAMES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_strobe,
  input  logic [1:0] rx_status,
  input  logic       user_avail,
  output logic       fdet_mode,
  output logic [1:0] tx_frame_sel,
  output logic       rdy_for_data
);
  logic      rst_sync_n;
  rx_cond_e  cond;
  hs_state_e state_q, state_d;
  logic      qual_hit, state_en;
  hs_out_t   outs;

  assign cond = rx_cond_e'(rx_status);

  lhs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  lhs_qual_counter #(
    .FILL_FRAMES (FILL_QUAL_FRAMES),
    .FREQ_FRAMES (FREQ_QUAL_FRAMES)
  ) u_qual (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .frame_strobe (frame_strobe),
    .state        (state_q),
    .cond         (cond),
    .qual_hit     (qual_hit)
  );

  lhs_next_state u_next (
    .state        (state_q),
    .frame_strobe (frame_strobe),
    .cond         (cond),
    .qual_hit     (qual_hit),
    .state_d      (state_d)
  );

  assign state_en = frame_strobe;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   state_q <= HS_START;
    else if (state_en) state_q <= state_d;
  end

  lhs_out_decode u_dec (
    .state        (state_q),
    .frame_strobe (frame_strobe),
    .cond         (cond),
    .user_avail   (user_avail),
    .outs         (outs)
  );

  assign fdet_mode    = outs.fdet;
  assign tx_frame_sel = outs.tx_sel;
  assign rdy_for_data = outs.ready;

  AST_FDET_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fdet_mode |-> (tx_frame_sel != 2'd2 && !rdy_for_data)); // R10
  AST_READY_RISES_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rdy_for_data) |-> $past(frame_strobe)); // R11
  AST_FILL0_RESTARTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_strobe && cond == RX_FILL0 && state_q != HS_START) |=> (state_q == HS_START)); // R6
  AST_FERR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_strobe && cond == RX_FERR) |=> (state_q == HS_START)); // R5
  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !frame_strobe |=> $stable(state_q)); // R2
  AST_READY_DROPS_NOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_strobe && (cond == RX_FERR || cond == RX_FILL0)) |-> !rdy_for_data); // R9
endmodule

// File: tb/link_handshake_ctrl_tb_top.sv
module link_handshake_ctrl_tb_top;
  localparam int FILL_N = 3;
  localparam int FREQ_N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_strobe = 1'b0;
  logic [1:0] rx_status = 2'd0;
  logic       user_avail = 1'b0;
  logic       fdet_mode, rdy_for_data;
  logic [1:0] tx_frame_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic       fdet;
    logic [1:0] tx;
    logic       rdy;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  int m_st  = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  link_handshake_ctrl #(
    .FILL_QUAL_FRAMES (FILL_N),
    .FREQ_QUAL_FRAMES (FREQ_N)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .rx_status    (rx_status),
    .user_avail   (user_avail),
    .fdet_mode    (fdet_mode),
    .tx_frame_sel (tx_frame_sel),
    .rdy_for_data (rdy_for_data)
  );

  task automatic model_step(input logic [1:0] c);
    case (m_st)
      0: if (c == 2'd2 || c == 2'd3) begin
           m_cnt++;
           if (m_cnt == FILL_N) begin m_st = 1; m_cnt = 0; end
         end else m_cnt = 0;
      1: if (c == 2'd0 || c == 2'd2) begin m_st = 0; m_cnt = 0; end
         else if (c == 2'd3) begin
           m_cnt++;
           if (m_cnt == FREQ_N) begin m_st = 2; m_cnt = 0; end
         end else m_cnt = 0;
      2: if (c == 2'd0 || c == 2'd2) m_st = 0; else m_st = 3;
      default: if (c == 2'd0 || c == 2'd2) m_st = 0;
    endcase
  endtask

  task automatic push_exp(input logic av, input string req);
    exp_t e;
    e.fdet = (m_st <= 1);
    e.tx   = (m_st == 0) ? 2'd0 : (m_st == 3 && av) ? 2'd2 : 2'd1;
    e.rdy  = (m_st == 3);
    e.req  = req;
    exp_q.push_back(e);
  endtask

  // driver: one strobed frame, with the same-cycle ready check
  task automatic send(input logic [1:0] c, input logic av, input string req);
    logic exp_r;
    @(negedge clk);
    frame_strobe = 1'b1; rx_status = c; user_avail = av;
    #1;
    exp_r = (m_st == 3) && !(c == 2'd0 || c == 2'd2);
    checks++;
    if (rdy_for_data !== exp_r) begin
      fails++;
      $display("FAIL R9 %s: same-cycle rdy_for_data=%b expected %b", req, rdy_for_data, exp_r);
    end
    model_step(c);
    push_exp(av, req);
    @(posedge clk);
    #2 frame_strobe = 1'b0;
  endtask

  task automatic idle(input logic [1:0] c, input logic av, input string req);
    @(negedge clk);
    frame_strobe = 1'b0; rx_status = c; user_avail = av;
    push_exp(av, req);
  endtask

  task automatic fills(input int n, input logic [1:0] c, input string req);
    for (int i = 0; i < n; i++) send(c, 1'b0, req);
  endtask

  task automatic bring_to_peer();
    fills(FILL_N, 2'd2, "R3");
    fills(FREQ_N, 2'd3, "R4");
  endtask

  // monitor: pops the scoreboard after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (fdet_mode !== e.fdet || tx_frame_sel !== e.tx || rdy_for_data !== e.rdy) begin
          fails++;
          $display("FAIL %s: fdet=%b tx=%0d rdy=%b expected fdet=%b tx=%0d rdy=%b",
                   e.req, fdet_mode, tx_frame_sel, rdy_for_data, e.fdet, e.tx, e.rdy);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle(2'd0, 1'b0, "R1");                 // reset state
    // R3: count cleared by error and by data
    send(2'd2, 1'b0, "R3"); send(2'd2, 1'b0, "R3"); send(2'd0, 1'b0, "R3");
    send(2'd2, 1'b0, "R3"); send(2'd3, 1'b0, "R3"); send(2'd1, 1'b0, "R3");
    fills(FILL_N, 2'd2, "R3");
    // R5: error in lock wait
    fills(2, 2'd3, "R4"); send(2'd0, 1'b0, "R5");
    fills(FILL_N, 2'd3, "R3");
    // R4: data clears frequency count
    fills(FREQ_N - 1, 2'd3, "R4"); send(2'd1, 1'b0, "R4");
    fills(FREQ_N, 2'd3, "R4");
    send(2'd0, 1'b0, "R5");                 // error in peer wait
    bring_to_peer();
    send(2'd2, 1'b0, "R6");                 // fill 0 in peer wait
    bring_to_peer();
    send(2'd1, 1'b1, "R7");                 // data moves to run
    // R2: unstrobed bad status ignored
    idle(2'd0, 1'b0, "R2"); idle(2'd2, 1'b1, "R2");
    send(2'd1, 1'b1, "R8"); send(2'd1, 1'b0, "R8"); send(2'd3, 1'b1, "R8");
    send(2'd2, 1'b1, "R6");                 // fill 0 in run, R9 drop
    bring_to_peer();
    send(2'd3, 1'b0, "R7");
    send(2'd0, 1'b1, "R5");                 // error in run
    fills(FILL_N, 2'd3, "R3");
    send(2'd2, 1'b0, "R6");                 // fill 0 in lock wait
    idle(2'd3, 1'b0, "R1");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule